// File: doc/BRIEF.md
# Non-Blocking Data Cache Miss Handler

This block takes loads that have already missed the data cache and tracks them until their data is delivered. It keeps two small structures. The fill table holds outstanding memory reads. The wait list holds loads that target a cache line whose fill is already in flight. A cacheable miss to a new line takes a fill-table slot and issues a 32-byte line read. Returned beats are written into the cache array one word at a time. The beat holding the word the load asked for goes straight to the register writeback port, without waiting for the rest of the line.

A cacheable miss to a line that already has a fill outstanding issues no memory traffic and is parked in the wait list. When the fill finishes, every parked load for that line is handed back to the cache lookup pipeline through a replay port, one per cycle, oldest first. A non-cacheable miss asks memory for exactly its access size and still holds a fill-table slot until its single beat returns and is forwarded. It never touches the cache array. Choosing and evicting a victim line belong to another block.

Top module: `mh_miss_handler`

## Requirements
- R1: A load is treated as cacheable only when `req_xlat_on`, `req_page_cach` and `req_dcache_on` are all 1; otherwise it is non-cacheable.
- R2: A cacheable load with no matching outstanding fill, accepted while `stall` is 0, raises `mrq_valid` in the same cycle. The request has `mrq_addr` equal to the load address with bits 4:0 cleared, `mrq_bytes` = 32, and `mrq_id` = the lowest-numbered free fill slot.
- R3: A non-cacheable load issues `mrq_addr` equal to its own address and `mrq_bytes` of 1, 2 or 4 for `req_size` codes 0, 1 and 2. Its single return beat drives `wb_valid` with the load's destination tag and the beat data, leaves `cw_en` at 0, and frees the slot.
- R4: `stall` is 1 whenever all fill slots or all wait-list entries are occupied. While `stall` is 1, a presented load is neither sent to memory nor parked.
- R5: A cacheable load whose line address (bits 31:5) equals that of an outstanding cacheable fill raises no memory request and is parked in the wait list.
- R6: A cacheable return beat whose word offset `mrt_word` equals the requested word offset (address bits 4:2) of its fill drives `wb_valid` in the same cycle, with that fill's destination tag and the beat data. Other beats drive no writeback.
- R7: Every cacheable return beat drives `cw_en` in the same cycle, with the fill's line address on `cw_line`, `mrt_word` on `cw_word` and the beat data on `cw_data`.
- R8: A cacheable fill completes on its eighth return beat, whatever order the word offsets arrive in. Its slot is free from the next cycle, so `stall` can fall and the slot can be reused.
- R9: Loads parked on a fill are presented on `rp_valid`/`rp_addr`/`rp_size`/`rp_dest` starting the cycle after that fill's last beat, one per cycle, in the order they were accepted. This order holds even when they sit in wait-list entries of other indices.
- R10: After reset `stall`, `mrq_valid`, `wb_valid`, `cw_en` and `rp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Missed load presented |
| req_addr | input | 32 | Load byte address |
| req_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| req_dest | input | 5 | Destination register tag |
| req_xlat_on | input | 1 | Address translation enabled |
| req_page_cach | input | 1 | Page marked cacheable |
| req_dcache_on | input | 1 | Data cache enabled |
| stall | output | 1 | Cannot accept a load this cycle |
| mrq_valid | output | 1 | Memory read request |
| mrq_addr | output | 32 | Memory read byte address |
| mrq_bytes | output | 6 | Memory read length in bytes |
| mrq_id | output | 2 | Fill slot tagging the request |
| mrt_valid | input | 1 | Memory return beat valid |
| mrt_id | input | 2 | Fill slot the beat belongs to |
| mrt_word | input | 3 | Word offset of the beat within the line |
| mrt_data | input | 32 | Beat data |
| cw_en | output | 1 | Cache array word write |
| cw_line | output | 27 | Line address for the write |
| cw_word | output | 3 | Word offset for the write |
| cw_data | output | 32 | Write data |
| wb_valid | output | 1 | Register writeback |
| wb_dest | output | 5 | Writeback destination tag |
| wb_data | output | 32 | Writeback data |
| rp_valid | output | 1 | Parked load replayed to the cache |
| rp_addr | output | 32 | Replayed load address |
| rp_size | output | 2 | Replayed load size code |
| rp_dest | output | 5 | Replayed load destination tag |

## Verification
The bench builds the handler with its defaults: four fill slots, four wait-list entries, a 32-byte line of eight 32-bit beats. With only four slots on each side, a handful of requests fill either structure, so the stall caused by a full fill table and the stall caused by a full wait list are each driven on its own. Eight beats per line let the bench return a line starting from a word other than the requested one and wrapping around, which exercises the completion count and the mid-line forward. A wait list this shallow must reuse a freed low index for a younger load while an older load still sits in a higher index, and that is what shows whether replay really follows acceptance order.

// File: rtl/mh_pkg.sv
package mh_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // All three enables must agree for the line to live in the cache.
  function automatic logic is_cacheable(input logic xlat_on, input logic page_cach,
                                        input logic dcache_on);
    return xlat_on & page_cach & dcache_on;
  endfunction

  // Exact byte count for an uncached access; the reserved code reads a word.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/mh_fill_buf.sv
module mh_fill_buf #(
  parameter int FILL_N = 4,
  parameter int FIDX_W = 2,
  parameter int LINE_W = 27,
  parameter int WSEL_W = 3,
  parameter int TAG_W  = 5,
  parameter int BEATS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [WSEL_W-1:0] alloc_word,
  input  logic [TAG_W-1:0]  alloc_dest,
  input  logic              alloc_cach,
  input  logic [LINE_W-1:0] look_line,
  input  logic              beat_valid,
  input  logic [FIDX_W-1:0] beat_id,
  output logic              full,
  output logic [FIDX_W-1:0] free_idx,
  output logic              hit,
  output logic [FIDX_W-1:0] hit_idx,
  output logic              fill_done,
  output logic [LINE_W-1:0] beat_line,
  output logic [WSEL_W-1:0] beat_fword,
  output logic [TAG_W-1:0]  beat_dest,
  output logic              beat_cach
);

  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

  logic [FILL_N-1:0] ent_vld, ent_cach;
  logic [LINE_W-1:0] ent_line [FILL_N];
  logic [WSEL_W-1:0] ent_word [FILL_N];
  logic [WSEL_W-1:0] ent_cnt  [FILL_N];
  logic [TAG_W-1:0]  ent_dest [FILL_N];

  assign beat_line  = ent_line[beat_id];
  assign beat_fword = ent_word[beat_id];
  assign beat_dest  = ent_dest[beat_id];
  assign beat_cach  = ent_cach[beat_id];
  assign full       = &ent_vld;

  // Uncached slots end on their only beat; cached ones on the last of the line.
  assign fill_done = beat_valid && ent_vld[beat_id] &&
                     (!ent_cach[beat_id] || ent_cnt[beat_id] == LAST_BEAT);

  // Line match ignores a slot retiring this very cycle.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = FILL_N - 1; i >= 0; i--) begin
      if (ent_vld[i] && ent_cach[i] && ent_line[i] == look_line &&
          !(fill_done && beat_id == FIDX_W'(i))) begin
        hit     = 1'b1;
        hit_idx = FIDX_W'(i);
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = FILL_N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = FIDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_cach <= '0;
      for (int i = 0; i < FILL_N; i++) begin
        ent_line[i] <= '0;
        ent_word[i] <= '0;
        ent_cnt[i]  <= '0;
        ent_dest[i] <= '0;
      end
    end else begin
      for (int i = 0; i < FILL_N; i++) begin
        if (fill_done && beat_id == FIDX_W'(i)) begin
          ent_vld[i] <= 1'b0;
          ent_cnt[i] <= '0;
        end else if (beat_valid && beat_id == FIDX_W'(i) && ent_vld[i]) begin
          ent_cnt[i] <= ent_cnt[i] + 1'b1;
        end
        if (alloc_en && free_idx == FIDX_W'(i)) begin
          ent_vld[i]  <= 1'b1;
          ent_cach[i] <= alloc_cach;
          ent_line[i] <= alloc_line;
          ent_word[i] <= alloc_word;
          ent_dest[i] <= alloc_dest;
          ent_cnt[i]  <= '0;
        end
      end
    end
  end

  // R4: the top never allocates into a full table.
  a_r4_alloc_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  // R8: memory only returns beats for live slots.
  a_r8_beat_to_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ent_vld[beat_id]);

  // R8: a completed slot is empty on the following cycle.
  a_r8_done_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !ent_vld[$past(beat_id)]);

endmodule

// File: rtl/mh_pend_buf.sv
module mh_pend_buf #(
  parameter int PEND_N = 4,
  parameter int PIDX_W = 2,
  parameter int FIDX_W = 2,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [FIDX_W-1:0] alloc_fidx,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic [TAG_W-1:0]  alloc_dest,
  input  logic              fill_done,
  input  logic [FIDX_W-1:0] done_idx,
  output logic              full,
  output logic              rp_valid,
  output logic [ADDR_W-1:0] rp_addr,
  output logic [1:0]        rp_size,
  output logic [TAG_W-1:0]  rp_dest
);

  logic [PEND_N-1:0] pvld, prdy, cand, grant;
  logic [PIDX_W-1:0] free_idx;
  logic [FIDX_W-1:0] pfidx [PEND_N];
  logic [ADDR_W-1:0] paddr [PEND_N];
  logic [1:0]        psize [PEND_N];
  logic [TAG_W-1:0]  pdest [PEND_N];
  // older[k][j]: entry j was accepted before entry k.
  logic [PEND_N-1:0] older [PEND_N];

  assign full = &pvld;
  assign cand = pvld & prdy;

  // The one ready entry with no older ready entry wins.
  always_comb begin
    for (int k = 0; k < PEND_N; k++) begin
      grant[k] = cand[k] && ((cand & older[k]) == '0);
    end
  end

  always_comb begin
    rp_valid = |grant;
    rp_addr  = '0;
    rp_size  = '0;
    rp_dest  = '0;
    for (int k = 0; k < PEND_N; k++) begin
      if (grant[k]) begin
        rp_addr = rp_addr | paddr[k];
        rp_size = rp_size | psize[k];
        rp_dest = rp_dest | pdest[k];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int k = PEND_N - 1; k >= 0; k--) begin
      if (!pvld[k]) free_idx = PIDX_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld <= '0;
      prdy <= '0;
      for (int k = 0; k < PEND_N; k++) begin
        pfidx[k] <= '0;
        paddr[k] <= '0;
        psize[k] <= '0;
        pdest[k] <= '0;
        older[k] <= '0;
      end
    end else begin
      for (int k = 0; k < PEND_N; k++) begin
        if (grant[k]) begin
          pvld[k] <= 1'b0;
          prdy[k] <= 1'b0;
        end else if (fill_done && pvld[k] && pfidx[k] == done_idx) begin
          prdy[k] <= 1'b1;
        end
        if (alloc_en) older[k][free_idx] <= 1'b0;
        if (alloc_en && free_idx == PIDX_W'(k)) begin
          pvld[k]  <= 1'b1;
          prdy[k]  <= 1'b0;
          pfidx[k] <= alloc_fidx;
          paddr[k] <= alloc_addr;
          psize[k] <= alloc_size;
          pdest[k] <= alloc_dest;
          older[k] <= pvld & ~grant;
        end
      end
    end
  end

  // R9: at most one parked load leaves per cycle.
  a_r9_one_replay: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: the top never parks into a full list.
  a_r4_pend_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  // R9: an entry becomes eligible only because a fill just finished.
  for (genvar g = 0; g < PEND_N; g++) begin : g_rdy_chk
    a_r9_ready_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prdy[g]) |-> $past(fill_done));
  end

endmodule

// File: rtl/mh_miss_handler.sv
module mh_miss_handler #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int FILL_N     = 4,
  parameter int PEND_N     = 4,
  parameter int TAG_W      = 5,
  localparam int DATA_W  = 8 * WORD_BYTES,
  localparam int BEATS   = LINE_BYTES / WORD_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int WB_W    = $clog2(WORD_BYTES),
  localparam int WSEL_W  = OFF_W - WB_W,
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int BYTES_W = OFF_W + 1,
  localparam int FIDX_W  = $clog2(FILL_N),
  localparam int PIDX_W  = $clog2(PEND_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [TAG_W-1:0]  req_dest,
  input  logic              req_xlat_on,
  input  logic              req_page_cach,
  input  logic              req_dcache_on,
  output logic              stall,
  output logic              mrq_valid,
  output logic [ADDR_W-1:0] mrq_addr,
  output logic [BYTES_W-1:0] mrq_bytes,
  output logic [FIDX_W-1:0] mrq_id,
  input  logic              mrt_valid,
  input  logic [FIDX_W-1:0] mrt_id,
  input  logic [WSEL_W-1:0] mrt_word,
  input  logic [DATA_W-1:0] mrt_data,
  output logic              cw_en,
  output logic [LINE_W-1:0] cw_line,
  output logic [WSEL_W-1:0] cw_word,
  output logic [DATA_W-1:0] cw_data,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_dest,
  output logic [DATA_W-1:0] wb_data,
  output logic              rp_valid,
  output logic [ADDR_W-1:0] rp_addr,
  output logic [1:0]        rp_size,
  output logic [TAG_W-1:0]  rp_dest
);

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:WB_W];
  endfunction

  // Named internal events.
  logic              req_cach, accept, f_alloc, p_alloc;
  logic              f_full, p_full, f_hit, f_done;
  logic [FIDX_W-1:0] f_free, f_hit_idx;
  logic [LINE_W-1:0] b_line;
  logic [WSEL_W-1:0] b_fword;
  logic [TAG_W-1:0]  b_dest;
  logic              b_cach;

  assign req_cach = mh_pkg::is_cacheable(req_xlat_on, req_page_cach, req_dcache_on);
  assign stall    = f_full | p_full;
  assign accept   = req_valid & ~stall;
  assign f_alloc  = accept & ~(req_cach & f_hit);
  assign p_alloc  = accept & req_cach & f_hit;

  assign mrq_valid = f_alloc;
  assign mrq_id    = f_free;
  assign mrq_addr  = req_cach ? {line_of(req_addr), {OFF_W{1'b0}}} : req_addr;
  assign mrq_bytes = req_cach ? BYTES_W'(LINE_BYTES)
                              : BYTES_W'(mh_pkg::size_bytes(req_size));

  assign cw_en   = mrt_valid & b_cach;
  assign cw_line = b_line;
  assign cw_word = mrt_word;
  assign cw_data = mrt_data;

  assign wb_valid = mrt_valid & (~b_cach | (mrt_word == b_fword));
  assign wb_dest  = b_dest;
  assign wb_data  = mrt_data;

  mh_fill_buf #(
    .FILL_N(FILL_N), .FIDX_W(FIDX_W), .LINE_W(LINE_W),
    .WSEL_W(WSEL_W), .TAG_W(TAG_W), .BEATS(BEATS)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (f_alloc),
    .alloc_line (line_of(req_addr)),
    .alloc_word (word_of(req_addr)),
    .alloc_dest (req_dest),
    .alloc_cach (req_cach),
    .look_line  (line_of(req_addr)),
    .beat_valid (mrt_valid),
    .beat_id    (mrt_id),
    .full       (f_full),
    .free_idx   (f_free),
    .hit        (f_hit),
    .hit_idx    (f_hit_idx),
    .fill_done  (f_done),
    .beat_line  (b_line),
    .beat_fword (b_fword),
    .beat_dest  (b_dest),
    .beat_cach  (b_cach)
  );

  mh_pend_buf #(
    .PEND_N(PEND_N), .PIDX_W(PIDX_W), .FIDX_W(FIDX_W),
    .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (p_alloc),
    .alloc_fidx (f_hit_idx),
    .alloc_addr (req_addr),
    .alloc_size (req_size),
    .alloc_dest (req_dest),
    .fill_done  (f_done),
    .done_idx   (mrt_id),
    .full       (p_full),
    .rp_valid   (rp_valid),
    .rp_addr    (rp_addr),
    .rp_size    (rp_size),
    .rp_dest    (rp_dest)
  );

  // R4: nothing reaches memory while the handler is stalling.
  a_r4_stall_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mrq_valid);

  // R5: a parked load never also goes to memory.
  a_r5_merge_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    p_alloc |-> !mrq_valid);

  // R6: writeback only ever accompanies a memory beat.
  a_r6_wb_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mrt_valid);

  // R7: a cache write never happens without returning data.
  a_r7_cw_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |-> mrt_valid);

endmodule

// File: tb/sim_mh_miss_handler.sv
`timescale 1ns/1ps
module sim_mh_miss_handler;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_xlat_on, req_page_cach, req_dcache_on;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [4:0]  req_dest;
  logic        stall, mrq_valid;
  logic [31:0] mrq_addr;
  logic [5:0]  mrq_bytes;
  logic [1:0]  mrq_id;
  logic        mrt_valid;
  logic [1:0]  mrt_id;
  logic [2:0]  mrt_word;
  logic [31:0] mrt_data;
  logic        cw_en;
  logic [26:0] cw_line;
  logic [2:0]  cw_word;
  logic [31:0] cw_data;
  logic        wb_valid;
  logic [4:0]  wb_dest;
  logic [31:0] wb_data;
  logic        rp_valid;
  logic [31:0] rp_addr;
  logic [1:0]  rp_size;
  logic [4:0]  rp_dest;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  mh_miss_handler u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_dest(req_dest),
    .req_xlat_on(req_xlat_on), .req_page_cach(req_page_cach), .req_dcache_on(req_dcache_on),
    .stall(stall), .mrq_valid(mrq_valid), .mrq_addr(mrq_addr), .mrq_bytes(mrq_bytes),
    .mrq_id(mrq_id), .mrt_valid(mrt_valid), .mrt_id(mrt_id), .mrt_word(mrt_word),
    .mrt_data(mrt_data), .cw_en(cw_en), .cw_line(cw_line), .cw_word(cw_word),
    .cw_data(cw_data), .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data),
    .rp_valid(rp_valid), .rp_addr(rp_addr), .rp_size(rp_size), .rp_dest(rp_dest)
  );

  // {addr, xlat, page, dcache, size, expect_cacheable, expect_bytes}
  localparam logic [43:0] VEC [6] = '{
    {32'h0000_1234, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 6'd32},
    {32'h0000_2008, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 6'd4},
    {32'h0000_300A, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 6'd2},
    {32'h0000_4003, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 6'd1},
    {32'h0000_507C, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 6'd32},
    {32'h0000_6000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 6'd32}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic clr();
    req_valid = 0; req_addr = '0; req_size = '0; req_dest = '0;
    req_xlat_on = 0; req_page_cach = 0; req_dcache_on = 0;
    mrt_valid = 0; mrt_id = '0; mrt_word = '0; mrt_data = '0;
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic [4:0] d,
                      input logic x, input logic p, input logic c);
    @(negedge clk);
    clr();
    req_valid = 1; req_addr = a; req_size = sz; req_dest = d;
    req_xlat_on = x; req_page_cach = p; req_dcache_on = c;
    #1;
  endtask

  task automatic csend(input logic [31:0] a, input logic [4:0] d);
    send(a, 2'd2, d, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic beat(input int id, input int w, input logic [31:0] dat);
    @(negedge clk);
    clr();
    mrt_valid = 1; mrt_id = 2'(id); mrt_word = 3'(w); mrt_data = dat;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    clr();
    #1;
  endtask

  // Return a whole line starting at word w0 and wrapping.
  task automatic fill_line(input int id, input int w0, input int fw,
                           input logic [4:0] dst, input logic [26:0] line);
    for (int b = 0; b < 8; b++) begin
      int w;
      logic [31:0] dat;
      w   = (w0 + b) % 8;
      dat = 32'hC0DE_0000 + 32'(id << 8) + 32'(w);
      beat(id, w, dat);
      check("R7 cw_en", cw_en, 1);
      check("R7 cw_line", cw_line, line);
      check("R7 cw_word", cw_word, w);
      check("R7 cw_data", cw_data, dat);
      check("R6 wb_valid on requested word only", wb_valid, (w == fw));
      if (w == fw) begin
        check("R6 wb_dest", wb_dest, dst);
        check("R6 wb_data", wb_data, dat);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  logic [43:0] e;
  logic [31:0] va;
  logic        vc;

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 stall", stall, 0);
    check("R10 mrq_valid", mrq_valid, 0);
    check("R10 wb_valid", wb_valid, 0);
    check("R10 cw_en", cw_en, 0);
    check("R10 rp_valid", rp_valid, 0);
    @(negedge clk);
    rst_n = 1;
    idle();
    check("R10 stall after release", stall, 0);

    // Vector walk: cacheability decision, request shape, return path.
    for (int v = 0; v < 6; v++) begin
      e  = VEC[v];
      va = e[43:12];
      vc = e[6];
      send(va, e[8:7], 5'(v + 1), e[11], e[10], e[9]);
      check("R1/R2/R3 mrq_valid", mrq_valid, 1);
      check("R1 mrq_bytes by cacheability", mrq_bytes, e[5:0]);
      check("R2/R3 mrq_addr", mrq_addr, vc ? (va & 32'hFFFF_FFE0) : va);
      check("R2 mrq_id lowest free", mrq_id, 0);
      if (vc) begin
        fill_line(0, int'(va[4:2]), int'(va[4:2]), 5'(v + 1), va[31:5]);
      end else begin
        beat(0, 0, 32'hBEEF_0000 + 32'(v));
        check("R3 wb_valid", wb_valid, 1);
        check("R3 wb_dest", wb_dest, 5'(v + 1));
        check("R3 wb_data", wb_data, 32'hBEEF_0000 + 32'(v));
        check("R3 no cache write", cw_en, 0);
      end
      idle();
      check("R8 slot freed", stall, 0);
    end

    // Fill table exhaustion and out-of-order completion.
    for (int i = 0; i < 4; i++) begin
      csend(32'h0001_0000 + 32'(i * 32'h100), 5'(8 + i));
      check("R2 mrq_valid", mrq_valid, 1);
      check("R2 mrq_id", mrq_id, i);
    end
    idle();
    check("R4 stall fill table full", stall, 1);
    csend(32'h0002_0000, 5'd30);
    check("R4 no issue while stalled", mrq_valid, 0);
    fill_line(2, 3, 0, 5'd10, 27'((32'h0001_0200) >> 5));
    idle();
    check("R8 stall released after eighth beat", stall, 0);
    csend(32'h0003_0000, 5'd9);
    check("R8 reused slot", mrq_id, 2);
    fill_line(0, 0, 0, 5'd8,  27'((32'h0001_0000) >> 5));
    fill_line(1, 0, 0, 5'd9,  27'((32'h0001_0100) >> 5));
    fill_line(3, 0, 0, 5'd11, 27'((32'h0001_0300) >> 5));
    fill_line(2, 0, 0, 5'd9,  27'((32'h0003_0000) >> 5));
    idle();
    check("R8 all slots free", stall, 0);

    // Merging onto in-flight fills and ordered replay.
    csend(32'h0000_7000, 5'd1);
    check("R2 line A issued", mrq_id, 0);
    csend(32'h0000_8000, 5'd2);
    check("R2 line B issued", mrq_id, 1);
    csend(32'h0000_7004, 5'd10);
    check("R5 merge A no issue", mrq_valid, 0);
    csend(32'h0000_8008, 5'd20);
    check("R5 merge B no issue", mrq_valid, 0);
    csend(32'h0000_7008, 5'd11);
    check("R5 merge A second", mrq_valid, 0);
    idle();
    check("R9 no replay before fill completes", rp_valid, 0);
    fill_line(0, 0, 0, 5'd1, 27'h380);
    idle();
    check("R9 replay first", rp_valid, 1);
    check("R9 replay first dest", rp_dest, 5'd10);
    check("R9 replay first addr", rp_addr, 32'h0000_7004);
    check("R9 replay size", rp_size, 2'd2);
    idle();
    check("R9 replay second dest", rp_dest, 5'd11);
    check("R9 replay second addr", rp_addr, 32'h0000_7008);
    idle();
    check("R9 line B loads still parked", rp_valid, 0);
    csend(32'h0000_800C, 5'd21);
    check("R5 merge B into reused entry", mrq_valid, 0);
    csend(32'h0000_8010, 5'd22);
    csend(32'h0000_8014, 5'd23);
    check("R5 merge B fourth", mrq_valid, 0);
    idle();
    check("R4 stall wait list full", stall, 1);
    send(32'h0000_9000, 2'd2, 5'd31, 1'b0, 1'b0, 1'b0);
    check("R4 uncached load blocked by full wait list", mrq_valid, 0);
    fill_line(1, 0, 0, 5'd2, 27'h400);
    idle();
    check("R9 order B1", rp_dest, 5'd20);
    check("R4 still full during first replay", stall, 1);
    idle();
    check("R9 order B2 from lower index", rp_dest, 5'd21);
    check("R4 released after replay", stall, 0);
    idle();
    check("R9 order B3", rp_dest, 5'd22);
    idle();
    check("R9 order B4", rp_dest, 5'd23);
    check("R9 order B4 addr", rp_addr, 32'h0000_8014);
    idle();
    check("R9 list drained", rp_valid, 0);

    done_flag = 1;
    summary();
  end

endmodule